// File: doc/BRIEF.md
# Masked Periodic Alarm Generator

This block holds an alarm time of day as four byte registers (seconds, minutes, hours, day of month). It compares that alarm with BCD time-of-day inputs that an external timekeeping counter drives, and it raises a single-cycle interrupt pulse when they match. A host loads the registers over a small synchronous register bus. Each write is checked for range and BCD form before the block accepts it, and any register can be read back.

Bit 7 of every alarm register is a repeat mask. The pattern of the four mask bits selects how often the alarm fires: once a month, once a day, once an hour, once a minute or once a second. The block evaluates a match only on the cycle when the one-second tick input is high. A matching second therefore yields exactly one pulse.

Top module: `alm_periodic_top`

## Requirements
- R1: While reset is asserted, and after it is released, all four alarm registers read 0x00 and `irq` is low.
- R2: Slot 0 (seconds) and slot 1 (minutes) accept a write only if bits 6:0 hold a BCD value from 00 to 59. A rejected write leaves the register unchanged.
- R3: Slot 2 (hours) accepts a write only if bits 5:0 hold a BCD value from 00 to 23.
- R4: Slot 3 (date) accepts a write only if bits 5:0 hold a non-zero BCD value.
- R5: A write is rejected if the checked field contains a nibble greater than 9.
- R6: An accepted write stores all 8 bits, including bit 7 and any bits outside the checked field. `rdata` shows the register that `addr` selects, combinationally.
- R7: When no register has bit 7 set (monthly rate), the block fires only if seconds[6:0], minutes[6:0], hours[5:0] and date[5:0] all equal the time inputs.
- R8: When only the date register has bit 7 set (daily rate), the block fires when seconds, minutes and hours match, whatever the date.
- R9: When the date and hours registers have bit 7 set (hourly rate), the block fires when seconds and minutes match.
- R10: When the date, hours and minutes registers have bit 7 set (minute rate), the block fires when seconds match.
- R11: Every other mask pattern, including any pattern with the seconds register masked, makes the block fire on every tick.
- R12: `irq` goes high for exactly one cycle, in the cycle after a tick that fires. It never goes high without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Slot select: 0 seconds, 1 minutes, 2 hours, 3 date |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected slot |
| sec_tick | input | 1 | One-cycle pulse once per second |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm pulse |

## Verification
The hardest case to reach is the one that separates each repeat rate from its neighbour. A tick whose time inputs match on every field except the one just past the masked boundary must stay silent, while a tick that differs only in a masked field must fire. The bench loads one alarm time and then changes the mask bits. For each rate it drives the time inputs straight to a matching instant and to a near-miss instant, so no real clock has to run for hours. A mask pattern that is not one of the four ordered patterns, with only the hours register masked, is also driven to show that it falls through to the every-second rate.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_SLOT = 4;
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOT);
  localparam int unsigned MASK_BIT = REG_W - 1;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_SEC  = 2'd0,
    SLOT_MIN  = 2'd1,
    SLOT_HOUR = 2'd2,
    SLOT_DATE = 2'd3
  } slot_e;

  typedef enum logic [2:0] {
    RATE_MONTH = 3'd0,
    RATE_DAY   = 3'd1,
    RATE_HOUR  = 3'd2,
    RATE_MIN   = 3'd3,
    RATE_SEC   = 3'd4
  } rate_e;

  function automatic logic digit_ok(input logic [3:0] n);
    return n <= 4'd9;
  endfunction
endpackage

// File: rtl/alm_wr_check.sv
module alm_wr_check
  import alm_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic [REG_W-1:0]  value,
  output logic              accept
);
  logic [3:0] ones;
  logic [2:0] tens7;
  logic [1:0] tens6;

  always_comb begin
    ones  = value[3:0];
    tens7 = value[6:4];
    tens6 = value[5:4];
    unique case (slot)
      SLOT_SEC, SLOT_MIN:
        accept = digit_ok(ones) && (tens7 <= 3'd5);
      SLOT_HOUR:
        accept = digit_ok(ones) &&
                 ((tens6 < 2'd2) || ((tens6 == 2'd2) && (ones <= 4'd3)));
      default:
        accept = digit_ok(ones) && (value[5:0] != 6'd0);
    endcase
  end
endmodule

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  input  logic                         accept,
  output logic [NUM_SLOT-1:0][REG_W-1:0] alarm_q
);
  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    logic             load;
    logic [REG_W-1:0] slot_d;

    always_comb begin
      load   = wr_en && accept && (addr == SLOT_W'(i));
      slot_d = alarm_q[i];
      if (load) slot_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    alarm_q[i] <= '0;
      else if (load) alarm_q[i] <= slot_d;
    end
  end
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SLOT-1:0][REG_W-1:0] alarm_q,
  input  logic                           sec_tick,
  input  logic [REG_W-1:0]               tod_sec,
  input  logic [REG_W-1:0]               tod_min,
  input  logic [REG_W-1:0]               tod_hour,
  input  logic [REG_W-1:0]               tod_date,
  output logic                           irq
);
  logic [NUM_SLOT-1:0] msk;
  rate_e               rate;
  logic                eq_sec, eq_min, eq_hour, eq_date;
  logic                hit;
  logic                irq_d;

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_msk
    assign msk[i] = alarm_q[i][MASK_BIT];
  end

  always_comb begin
    // mask pattern ordered {date, hour, min, sec}
    unique case ({msk[SLOT_DATE], msk[SLOT_HOUR], msk[SLOT_MIN], msk[SLOT_SEC]})
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end

  always_comb begin
    eq_sec  = alarm_q[SLOT_SEC][6:0]  == tod_sec[6:0];
    eq_min  = alarm_q[SLOT_MIN][6:0]  == tod_min[6:0];
    eq_hour = alarm_q[SLOT_HOUR][5:0] == tod_hour[5:0];
    eq_date = alarm_q[SLOT_DATE][5:0] == tod_date[5:0];
    unique case (rate)
      RATE_MONTH: hit = eq_sec && eq_min && eq_hour && eq_date;
      RATE_DAY:   hit = eq_sec && eq_min && eq_hour;
      RATE_HOUR:  hit = eq_sec && eq_min;
      RATE_MIN:   hit = eq_sec;
      default:    hit = 1'b1;
    endcase
    irq_d = sec_tick && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/alm_periodic_top.sv
module alm_periodic_top
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              sec_tick,
  input  logic [7:0]        tod_sec,
  input  logic [7:0]        tod_min,
  input  logic [7:0]        tod_hour,
  input  logic [7:0]        tod_date,
  output logic              irq
);
  logic [NUM_SLOT-1:0][REG_W-1:0] alarm_q;
  logic                           accept;

  alm_wr_check u_chk_wr (
    .slot   (addr),
    .value  (wdata),
    .accept (accept)
  );

  alm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .accept  (accept),
    .alarm_q (alarm_q)
  );

  alm_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .alarm_q  (alarm_q),
    .sec_tick (sec_tick),
    .tod_sec  (tod_sec),
    .tod_min  (tod_min),
    .tod_hour (tod_hour),
    .tod_date (tod_date),
    .irq      (irq)
  );

  assign rdata = alarm_q[addr];
endmodule

// File: rtl/alm_chk.sv
module alm_chk
  import alm_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [1:0]                     addr,
  input logic                           sec_tick,
  input logic [7:0]                     tod_date,
  input logic                           irq,
  input logic [NUM_SLOT-1:0][REG_W-1:0] regs_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (irq == 1'b0 && regs_q == '0));

  // R12
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sec_tick));

  // R12
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sec_tick) |=> !irq);

  // R11
  every_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && regs_q[0][MASK_BIT]) |=> irq);

  // R7
  month_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && regs_q[0][7] == 1'b0 && regs_q[1][7] == 1'b0 &&
     regs_q[2][7] == 1'b0 && regs_q[3][7] == 1'b0 &&
     tod_date[5:0] != regs_q[3][5:0]) |=> !irq);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

  // R6
  other_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 2'd0) |=> $stable(regs_q[0]));
endmodule

bind alm_periodic_top alm_chk u_alm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .sec_tick (sec_tick),
  .tod_date (tod_date),
  .irq      (irq),
  .regs_q   (alarm_q)
);

// File: tb/tb_alm_periodic_top.sv
module tb_alm_periodic_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       sec_tick;
  logic [7:0] tod_sec, tod_min, tod_hour, tod_date;
  logic       irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  alm_periodic_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sec_tick(sec_tick), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hour(tod_hour), .tod_date(tod_date), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] slot, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; addr = slot; wdata = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] slot, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = slot;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic tick_check(input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] d,
                            input logic exp, input string tag);
    @(negedge clk);
    tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check(tag, {7'd0, irq}, {7'd0, exp});
    @(negedge clk);
    check({tag, " pulse end R12"}, {7'd0, irq}, 8'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'd0, irq}, 8'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rd_check(2'(i), 8'h00, "R1 reg after reset");
    check("R1 irq after reset", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_limits();
    wr(0, 8'h59); rd_check(0, 8'h59, "R2 sec 59 accepted");
    wr(0, 8'h60); rd_check(0, 8'h59, "R2 sec 60 rejected");
    wr(1, 8'h85); rd_check(1, 8'h85, "R2 R6 min masked 05 accepted");
    wr(1, 8'h5A); rd_check(1, 8'h85, "R5 min nibble A rejected");
    wr(2, 8'h23); rd_check(2, 8'h23, "R3 hour 23 accepted");
    wr(2, 8'h24); rd_check(2, 8'h23, "R3 hour 24 rejected");
    wr(2, 8'h1A); rd_check(2, 8'h23, "R5 hour nibble A rejected");
    wr(2, 8'hC5); rd_check(2, 8'hC5, "R6 hour upper bits stored");
    wr(3, 8'h00); rd_check(3, 8'h00, "R4 date 00 rejected");
    wr(3, 8'h31); rd_check(3, 8'h31, "R4 date 31 accepted");
    wr(3, 8'h80); rd_check(3, 8'h31, "R4 date masked 00 rejected");
    wr(3, 8'h3F); rd_check(3, 8'h31, "R5 date nibble F rejected");
  endtask

  task automatic load(input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] d);
    wr(0, s); wr(1, m); wr(2, h); wr(3, d);
  endtask

  task automatic t_month();
    load(8'h30, 8'h15, 8'h08, 8'h12);
    tick_check(8'h30, 8'h15, 8'h08, 8'h12, 1'b1, "R7 monthly full match");
    tick_check(8'h30, 8'h15, 8'h08, 8'h13, 1'b0, "R7 monthly date differs");
  endtask

  task automatic t_day();
    load(8'h30, 8'h15, 8'h08, 8'h92);
    tick_check(8'h30, 8'h15, 8'h08, 8'h05, 1'b1, "R8 daily any date");
    tick_check(8'h30, 8'h15, 8'h09, 8'h05, 1'b0, "R8 daily hour differs");
  endtask

  task automatic t_hour();
    load(8'h30, 8'h15, 8'h88, 8'h92);
    tick_check(8'h30, 8'h15, 8'h17, 8'h05, 1'b1, "R9 hourly any hour");
    tick_check(8'h30, 8'h16, 8'h17, 8'h05, 1'b0, "R9 hourly minute differs");
  endtask

  task automatic t_minute();
    load(8'h30, 8'h95, 8'h88, 8'h92);
    tick_check(8'h30, 8'h42, 8'h17, 8'h05, 1'b1, "R10 minute rate any minute");
    tick_check(8'h31, 8'h42, 8'h17, 8'h05, 1'b0, "R10 minute rate second differs");
  endtask

  task automatic t_second();
    load(8'hB0, 8'h95, 8'h88, 8'h92);
    tick_check(8'h07, 8'h42, 8'h17, 8'h05, 1'b1, "R11 seconds masked");
    load(8'h30, 8'h15, 8'h88, 8'h12);
    tick_check(8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R11 odd mask pattern");
  endtask

  task automatic t_no_tick();
    @(negedge clk);
    tod_sec = 8'h30; tod_min = 8'h15; tod_hour = 8'h08; tod_date = 8'h12;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R12 no pulse without tick", {7'd0, irq}, 8'd0);
    end
  endtask

  initial begin
    wr_en = 0; addr = 0; wdata = 0; sec_tick = 0;
    tod_sec = 0; tod_min = 0; tod_hour = 0; tod_date = 8'h01;
    rst_n = 0;
    t_reset();
    t_limits();
    t_month();
    t_day();
    t_hour();
    t_minute();
    t_second();
    t_no_tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule